// File: doc/BRIEF.md
# Lock-Aware Glitch-Free Clock Selector

This block picks the master clock for the output clock tree of an audio receiver. There are two candidates: the clock recovered by a PLL and a free-running crystal reference. In automatic operation the PLL clock drives the output while the PLL reports lock, and the reference takes over when lock is lost. A control bit can pin the output to the reference regardless of lock. A second control bit stops the PLL oscillator. Whenever the oscillator is stopped, the reference is used.

Each candidate clock passes through an enable that only changes while that clock is low. The enable that is on is always turned off before the other one is turned on. As a result, a change of source never produces a shortened pulse or two overlapping pulses. If the PLL clock is requested while the PLL is unlocked, nothing changes at that moment. The switch to the PLL happens by itself once lock arrives, with no further write.

A status output reports, in the reference clock domain, whether the PLL clock is the one currently gated to the output.

Top module: `lockclk_sel`

## Requirements
- R1: While reset is asserted and right after it is released, `clk_out` follows `clk_ref` and `pll_active` is 0.
- R2: With `pll_run`=1 and `force_ref`=0, the output settles on the PLL clock within 40 reference periods of `pll_lock_async` becoming 1, and returns to the reference within 40 reference periods of it becoming 0.
- R3: A change of source caused by lock or by `force_ref` never produces a high or low interval on `clk_out` shorter than the shorter half period of the two input clocks.
- R4: The reference enable and the PLL enable are never on at the same time (break before make).
- R5: With `pll_run`=0, the output settles on the reference within 40 reference periods even when the PLL clock has stopped, and stays there whatever the lock and override inputs are.
- R6: Once settled, `pll_active` is 1 exactly when `clk_out` carries the PLL clock, and 0 exactly when it carries the reference.
- R7: With `force_ref`=1, the reference is used whatever the lock state.
- R8: Clearing `force_ref` while unlocked leaves the reference in place. A later rise of lock alone then moves the output to the PLL clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Crystal reference clock; clocks the decision logic |
| clk_pll | input | 1 | Recovered PLL clock; may stop while `pll_run` is 0 |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_lock_async | input | 1 | PLL lock flag, asynchronous to both clocks |
| force_ref | input | 1 | 1 pins the source to the reference; 0 lets lock decide |
| pll_run | input | 1 | 1 keeps the PLL oscillator running; 0 stops it and selects the reference |
| clk_out | output | 1 | Selected, glitch-free master clock |
| pll_active | output | 1 | 1 when the PLL clock is gated to `clk_out` (reference domain) |

## Verification
Suppose an enable flop changes in the wrong half of its clock. The next switch then shows a short pulse on `clk_out`, within one period of the enable change. Suppose the handshake lets both enables open together. The output then shows merged or extra edges during the switch, about two to four periods after the select changes. A selection flop stuck in the wrong state cannot be hidden: within forty reference periods the output follows the wrong clock and `pll_active` disagrees with the lock and override inputs. A PLL side that fails to drop its enable when the oscillator stops shows up as the output never returning to the reference.

// File: rtl/clksel_pkg.sv
`timescale 1ns/100ps
package clksel_pkg;

  typedef enum logic {
    SRC_REF = 1'b0,
    SRC_PLL = 1'b1
  } src_e;

  // Source wanted by the control inputs: the PLL only when it runs, is locked
  // and the override does not pin the reference.
  function automatic src_e pick_source(input logic run, input logic pin_ref,
                                       input logic locked);
    return (run && !pin_ref && locked) ? SRC_PLL : SRC_REF;
  endfunction

  // The handshake has come to rest on the current choice.
  // Reference: its gate is open, the PLL domain has seen it open, PLL is off.
  // PLL: reference gate closed and the PLL gate is reported open.
  function automatic logic is_settled(input src_e want, input logic ref_on,
                                      input logic ref_seen, input logic pll_seen);
    if (want == SRC_REF) return ref_on && ref_seen && !pll_seen;
    return !ref_on && pll_seen;
  endfunction

endpackage

// File: rtl/clksel_sync.sv
`timescale 1ns/100ps
module clksel_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] q_r;
    if (g == 0) begin : g_head
      assign src = d;
    end else begin : g_tail
      assign src = g_stage[g-1].q_r;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= RST_VAL;
      else        q_r <= src;
    end
  end

  assign q = g_stage[STAGES-1].q_r;

endmodule

// File: rtl/clksel_gate.sv
`timescale 1ns/100ps
module clksel_gate #(
  parameter int STAGES = 2,
  parameter bit RST_ON = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic en,
  output logic gclk
);

  localparam int PRE_STAGES = STAGES - 1;

  logic req_s;

  // Rising-edge stages take the request into this clock domain.
  clksel_sync #(
    .WIDTH  (1),
    .STAGES (PRE_STAGES),
    .RST_VAL(RST_ON)
  ) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (req),
    .q    (req_s)
  );

  // The last stage moves on the falling edge, so the gate opens or closes only
  // while the clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en <= RST_ON;
    else        en <= req_s;
  end

  assign gclk = clk & en;

endmodule

// File: rtl/lockclk_sel.sv
`timescale 1ns/100ps
module lockclk_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_ref,
  input  logic clk_pll,
  input  logic rst_n,
  input  logic pll_lock_async,
  input  logic force_ref,
  input  logic pll_run,
  output logic clk_out,
  output logic pll_active
);
  import clksel_pkg::*;

  localparam int CTL_W = 3;

  logic [CTL_W-1:0] ctl_s;
  logic             run_s, pin_s, lock_s;
  src_e             want_q;
  logic             want_pll;
  logic             settled;
  logic             rst_pll_n;
  logic             want_p, ref_en_p;
  logic             pll_en_r, ref_echo;
  logic             ref_req, pll_req;
  logic             ref_en, pll_en;
  logic             ref_g, pll_g;

  // Control inputs brought into the reference domain.
  clksel_sync #(
    .WIDTH  (CTL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL('0)
  ) u_ctl_sync (
    .clk  (clk_ref),
    .rst_n(rst_n),
    .d    ({pll_run, force_ref, pll_lock_async}),
    .q    (ctl_s)
  );

  assign run_s  = ctl_s[2];
  assign pin_s  = ctl_s[1];
  assign lock_s = ctl_s[0];

  assign settled = is_settled(want_q, ref_en, ref_echo, pll_en_r);

  // The selection may only move once the previous switch has fully landed.
  // A stopped PLL overrides this, because its side can no longer answer.
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)       want_q <= SRC_REF;
    else if (!run_s)  want_q <= SRC_REF;
    else if (settled) want_q <= pick_source(run_s, pin_s, lock_s);
  end

  assign want_pll = (want_q == SRC_PLL);

  // The PLL domain is held cleared while the oscillator is stopped.
  assign rst_pll_n = rst_n & pll_run;

  clksel_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_want_p (
    .clk(clk_pll), .rst_n(rst_pll_n), .d(want_pll), .q(want_p)
  );

  clksel_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_refen_p (
    .clk(clk_pll), .rst_n(rst_pll_n), .d(ref_en), .q(ref_en_p)
  );

  clksel_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pllen_r (
    .clk(clk_ref), .rst_n(rst_n), .d(pll_en), .q(pll_en_r)
  );

  clksel_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_echo_r (
    .clk(clk_ref), .rst_n(rst_n), .d(ref_en_p), .q(ref_echo)
  );

  // Each side opens only after it sees the other side closed.
  assign ref_req = !want_pll && !pll_en_r;
  assign pll_req = want_p && !ref_en_p;

  clksel_gate #(.STAGES(SYNC_STAGES), .RST_ON(1'b1)) u_ref_gate (
    .clk(clk_ref), .rst_n(rst_n), .req(ref_req), .en(ref_en), .gclk(ref_g)
  );

  clksel_gate #(.STAGES(SYNC_STAGES), .RST_ON(1'b0)) u_pll_gate (
    .clk(clk_pll), .rst_n(rst_pll_n), .req(pll_req), .en(pll_en), .gclk(pll_g)
  );

  assign clk_out    = ref_g | pll_g;
  assign pll_active = pll_en_r;

endmodule

// File: rtl/lockclk_sel_chk.sv
`timescale 1ns/100ps
module lockclk_sel_chk (
  input logic clk_ref,
  input logic clk_pll,
  input logic rst_n,
  input logic pll_run,
  input logic ref_en,
  input logic pll_en,
  input logic pll_active
);

  AST_EXCL_AT_REF: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !(ref_en && pll_en))
    else $error("both gates open at reference edge"); // R4

  AST_EXCL_AT_PLL: assert property (@(posedge clk_pll) disable iff (!rst_n)
    !(ref_en && pll_en))
    else $error("both gates open at PLL edge"); // R4

  AST_STATUS_EXCL: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pll_active |-> !ref_en)
    else $error("status reports PLL while reference gate open"); // R6

  AST_STOP_CLOSES: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !pll_run |-> !pll_en)
    else $error("PLL gate open while oscillator stopped"); // R5

  always @(ref_en) begin
    if (rst_n) begin
      AST_REF_GATE_LOW: assert (!clk_ref)
        else $error("reference gate moved while clock high"); // R3
    end
  end

  always @(pll_en) begin
    if (rst_n && pll_run) begin
      AST_PLL_GATE_LOW: assert (!clk_pll)
        else $error("PLL gate moved while clock high"); // R3
    end
  end

endmodule

bind lockclk_sel lockclk_sel_chk u_chk (
  .clk_ref   (clk_ref),
  .clk_pll   (clk_pll),
  .rst_n     (rst_n),
  .pll_run   (pll_run),
  .ref_en    (ref_en),
  .pll_en    (pll_en),
  .pll_active(pll_active)
);

// File: tb/tb_lockclk_sel.sv
`timescale 1ns/100ps
module tb_lockclk_sel;

  localparam realtime REF_PERIOD = 10.0;
  localparam realtime PLL_HALF   = 3.5;
  localparam realtime MIN_PULSE  = 3.4;
  localparam int      SETTLE     = 40;
  localparam int      WATCHDOG   = 100000;

  logic clk_ref = 1'b0;
  logic clk_pll = 1'b0;
  logic pll_on  = 1'b1;
  logic rst_n   = 1'b0;
  logic lock    = 1'b0;
  logic pin_ref = 1'b0;
  logic run     = 1'b1;
  logic clk_out;
  logic pll_active;

  int n_cmp  = 0;
  int n_bad  = 0;
  int glitches = 0;
  bit mon_en = 1'b0;
  bit done   = 1'b0;
  realtime last_t = 0.0;

  always #(REF_PERIOD/2) clk_ref = ~clk_ref;
  always #(PLL_HALF) clk_pll = pll_on ? ~clk_pll : 1'b0;

  lockclk_sel dut (
    .clk_ref       (clk_ref),
    .clk_pll       (clk_pll),
    .rst_n         (rst_n),
    .pll_lock_async(lock),
    .force_ref     (pin_ref),
    .pll_run       (run),
    .clk_out       (clk_out),
    .pll_active    (pll_active)
  );

  // Pulse-width monitor on the output (R3).
  always @(clk_out) begin
    if (mon_en && ($realtime - last_t) < MIN_PULSE) glitches++;
    last_t = $realtime;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(posedge clk_ref);
  endtask

  // Compare clk_out with the expected source in both halves of the reference.
  task automatic chk_follow(input string tag, input logic use_pll);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk_ref); #1.2;
      chk(tag, clk_out, use_pll ? clk_pll : clk_ref);
      @(negedge clk_ref); #1.2;
      chk(tag, clk_out, use_pll ? clk_pll : clk_ref);
    end
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Apply a lock/override pair with the PLL running and check the outcome.
  task automatic apply(input logic f, input logic l);
    logic exp_pll;
    string tag;
    pin_ref = f;
    lock    = l;
    wait_ref(SETTLE);
    exp_pll = l && !f;
    tag = f ? "R7" : "R2";
    @(posedge clk_ref); #1.2;
    chk(tag, pll_active, exp_pll);
    chk_follow("R6", exp_pll);
  endtask

  initial begin
    // R1: state during and after reset
    wait_ref(5);
    #1.2;
    chk("R1", pll_active, 1'b0);
    chk_follow("R1", 1'b0);
    @(negedge clk_ref);
    rst_n = 1'b1;
    wait_ref(3);
    #1.2;
    chk("R1", pll_active, 1'b0);
    chk_follow("R1", 1'b0);
    mon_en = 1'b1;

    // R2 R6 R7: every transition between the four override/lock pairs
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        apply(a[1], a[0]);
        apply(b[1], b[0]);
      end
    end

    // R8: PLL requested while unlocked, then lock alone completes the switch
    apply(1'b1, 1'b0);
    pin_ref = 1'b0;
    wait_ref(SETTLE);
    @(posedge clk_ref); #1.2;
    chk("R8", pll_active, 1'b0);
    chk_follow("R8", 1'b0);
    lock = 1'b1;
    wait_ref(SETTLE);
    @(posedge clk_ref); #1.2;
    chk("R8", pll_active, 1'b1);
    chk_follow("R8", 1'b1);

    // R5: stop the oscillator while locked on the PLL
    mon_en = 1'b0;
    run    = 1'b0;
    pll_on = 1'b0;
    wait_ref(SETTLE);
    @(posedge clk_ref); #1.2;
    chk("R5", pll_active, 1'b0);
    chk_follow("R5", 1'b0);
    // R5: stays on the reference whatever lock and override do
    pin_ref = 1'b0; lock = 1'b0;
    wait_ref(10);
    lock = 1'b1;
    wait_ref(SETTLE);
    @(posedge clk_ref); #1.2;
    chk("R5", pll_active, 1'b0);
    chk_follow("R5", 1'b0);
    // R5: oscillator running but stopped by the control bit
    pll_on = 1'b1;
    wait_ref(10);
    mon_en = 1'b1;
    wait_ref(SETTLE);
    @(posedge clk_ref); #1.2;
    chk("R5", pll_active, 1'b0);
    chk_follow("R5", 1'b0);
    // R2: restarting returns to the PLL once locked
    run = 1'b1;
    wait_ref(SETTLE);
    @(posedge clk_ref); #1.2;
    chk("R2", pll_active, 1'b1);
    chk_follow("R6", 1'b1);

    // R3 R4: no short or merged pulse in any switch above
    chk("R3", glitches == 0, 1'b1);

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_ref);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished at %0t", $time);
      report();
      $finish;
    end
  end

endmodule